// File: doc/BRIEF.md
# Host Slave Access Detector with Relocatable Register Window

This block watches the host bus while the coprocessor is not driving it. It reports a host cycle when chip select and a read or write strobe are active together. For the length of that cycle it raises a slave-enable window, and that window can enable an external data transceiver directly. At the first cycle of each access the block sorts it into one of two kinds. The first kind is an access to a 128-byte internal register block whose base and address space (memory or I/O) can be moved. The second kind is an access that is forwarded to graphics memory. The block also latches the address, the direction and the byte lanes, and holds them for the whole access.

A relocation register sits at word 0 of the register block and sets the block's position. It holds the block base as address bits 21:7 and a flag that maps the block into memory space or into I/O space. The host reprograms it with an ordinary write into the block, and the new position applies from the next access.

Top module: `host_slave_port`

## Requirements
- R1: With `bus_master` low, chip select (`cs_n`) low together with `rd_n` or `wr_n` low starts an access. `sen` goes high at the next rising clock edge and stays high while that condition holds.
- R2: `sen` drops at the first rising edge at which the access condition is no longer true. After that edge `win_hit`, `mem_fwd`, `lane_lo`, `lane_hi`, `acc_write`, `acc_addr` and `rdata` are all 0.
- R3: While `bus_master` is high no access is detected: `sen` stays low and a host write cannot change the relocation register.
- R4: When `sen` is high, exactly one of `win_hit` and `mem_fwd` is high. `win_hit` is high when `addr[21:7]` equals the programmed base and `mio` equals the programmed mapping; otherwise `mem_fwd` is high.
- R5: An address inside the block range whose `mio` value differs from the programmed mapping is forwarded to memory.
- R6: Byte lanes are `lane_lo = !addr[0]` and `lane_hi = !bhe_n`. So `bhe_n=0,addr[0]=0` is a word, `bhe_n=1,addr[0]=0` is the low byte, and `bhe_n=0,addr[0]=1` is the high byte.
- R7: A write that hits the block with `addr[6:1]==0` loads the relocation register. `wdata[7:0]` is loaded when `lane_lo` is set and `wdata[15:8]` when `lane_hi` is set. Bit 0 is the mapping (1 = memory, 0 = I/O) and bits 15:1 are the base (address bits 21:7).
- R8: After reset the relocation register holds base 0 with I/O mapping, and every output is 0.
- R9: A read that hits the block at word 0 returns the relocation register on `rdata` for the whole access. Any other read returns 0.
- R10: The classification, lanes, direction, `acc_addr` and `rdata` are captured in the first cycle of an access and held until it ends. A relocation write changes the classification of later accesses only.
- R11: The block covers base through base+127 inclusive. base+128 and base-1 are forwarded to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_master | input | 1 | High while the coprocessor owns the host bus |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| bhe_n | input | 1 | Active-low byte-high enable |
| addr | input | 22 | Host byte address |
| wdata | input | 16 | Host write data |
| sen | output | 1 | Slave-enable window |
| win_hit | output | 1 | Access targets the register block |
| mem_fwd | output | 1 | Access is forwarded to graphics memory |
| lane_lo | output | 1 | Low byte lane active |
| lane_hi | output | 1 | High byte lane active |
| acc_write | output | 1 | Access is a write |
| acc_addr | output | 22 | Address captured at access start |
| rdata | output | 16 | Read data for register-block reads |

## Verification
The hardest case to reach from the ports is an access whose own write moves the block away from the address it targets. The classification must stay as captured until that access ends, and only the next access may see the new base and mapping. The stimulus programs a base and a memory mapping with a word write. It then probes base-1, base, base+127 and base+128 in both address spaces, and changes the mapping back with a low-byte-only write. Randomized accesses follow, each separated by an idle gap, and most of them fall near the current base.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int ADDR_W   = 22;
  localparam int DATA_W   = 16;
  localparam int WIN_BITS = 7;
  localparam int BASE_W   = ADDR_W - WIN_BITS;
  localparam int LANES    = DATA_W / 8;

  // true when the address falls inside the relocated block and the space matches
  function automatic logic window_match(input logic [ADDR_W-1:0] a,
                                        input logic [BASE_W-1:0] base,
                                        input logic map_mem,
                                        input logic mio);
    return (a[ADDR_W-1:WIN_BITS] == base) && (mio == map_mem);
  endfunction

  // byte-lane enables: bit 0 low byte, bit 1 high byte
  function automatic logic [LANES-1:0] lane_decode(input logic bhe_n, input logic a0);
    return {~bhe_n, ~a0};
  endfunction
endpackage

// File: rtl/hsp_detect.sv
module hsp_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_master,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic access_on,
  output logic access_start,
  output logic sen
);
  logic on_q;

  assign access_on    = ~bus_master & ~cs_n & (~rd_n | ~wr_n);
  assign access_start = access_on & ~on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
      sen  <= 1'b0;
    end else begin
      on_q <= access_on;
      sen  <= access_on;
    end
  end

  a_r1_sen_rises: assert property (@(posedge clk) disable iff (!rst_n)
    access_start |=> sen);
  a_r2_sen_falls: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(access_on) |=> !sen);
  a_r3_master_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    bus_master |=> !sen);
endmodule

// File: rtl/hsp_reloc.sv
module hsp_reloc
  import hsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reloc_q,
  output logic [BASE_W-1:0] base,
  output logic              map_mem
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        reloc_q[8*i +: 8] <= 8'h00;
      else if (load && lane_en[i])
        reloc_q[8*i +: 8] <= wdata[8*i +: 8];
    end
  end

  assign base    = reloc_q[BASE_W:1];
  assign map_mem = reloc_q[0];

  a_r7_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(reloc_q));
endmodule

// File: rtl/hsp_decode.sv
module hsp_decode
  import hsp_pkg::*;
#(
  parameter int RELOC_WORD = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_on,
  input  logic              access_start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mio,
  input  logic              bhe_n,
  input  logic              wr_n,
  input  logic [BASE_W-1:0] base,
  input  logic              map_mem,
  input  logic [DATA_W-1:0] reloc_q,
  output logic              reloc_load,
  output logic [LANES-1:0]  lane_now,
  output logic              win_hit,
  output logic              mem_fwd,
  output logic [LANES-1:0]  lanes,
  output logic              acc_write,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] rdata
);
  logic hit_now, reloc_word_sel;

  assign hit_now        = window_match(addr, base, map_mem, mio);
  assign lane_now       = lane_decode(bhe_n, addr[0]);
  assign reloc_word_sel = (addr[WIN_BITS-1:1] == (WIN_BITS-1)'(RELOC_WORD));
  assign reloc_load     = access_start & hit_now & ~wr_n & reloc_word_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_hit   <= 1'b0;
      mem_fwd   <= 1'b0;
      lanes     <= '0;
      acc_write <= 1'b0;
      acc_addr  <= '0;
      rdata     <= '0;
    end else if (access_start) begin
      win_hit   <= hit_now;
      mem_fwd   <= ~hit_now;
      lanes     <= lane_now;
      acc_write <= ~wr_n;
      acc_addr  <= addr;
      rdata     <= (hit_now && wr_n && reloc_word_sel) ? reloc_q : '0;
    end else if (!access_on) begin
      win_hit   <= 1'b0;
      mem_fwd   <= 1'b0;
      lanes     <= '0;
      acc_write <= 1'b0;
      acc_addr  <= '0;
      rdata     <= '0;
    end
  end

  a_r10_hold_during_access: assert property (@(posedge clk) disable iff (!rst_n)
    (access_on && !access_start) |=> $stable({win_hit, mem_fwd, lanes, acc_write, acc_addr, rdata}));
  a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !access_on |=> !(win_hit || mem_fwd || acc_write));
endmodule

// File: rtl/host_slave_port.sv
module host_slave_port
  import hsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_master,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              mio,
  input  logic              bhe_n,
  input  logic [21:0]       addr,
  input  logic [15:0]       wdata,
  output logic              sen,
  output logic              win_hit,
  output logic              mem_fwd,
  output logic              lane_lo,
  output logic              lane_hi,
  output logic              acc_write,
  output logic [21:0]       acc_addr,
  output logic [15:0]       rdata
);
  logic              access_on, access_start, reloc_load, map_mem;
  logic [LANES-1:0]  lane_now, lanes;
  logic [DATA_W-1:0] reloc_q;
  logic [BASE_W-1:0] base;

  hsp_detect u_detect (
    .clk(clk), .rst_n(rst_n), .bus_master(bus_master), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .access_on(access_on),
    .access_start(access_start), .sen(sen)
  );

  hsp_reloc u_reloc (
    .clk(clk), .rst_n(rst_n), .load(reloc_load), .lane_en(lane_now),
    .wdata(wdata), .reloc_q(reloc_q), .base(base), .map_mem(map_mem)
  );

  hsp_decode #(.RELOC_WORD(0)) u_decode (
    .clk(clk), .rst_n(rst_n), .access_on(access_on),
    .access_start(access_start), .addr(addr), .mio(mio), .bhe_n(bhe_n),
    .wr_n(wr_n), .base(base), .map_mem(map_mem), .reloc_q(reloc_q),
    .reloc_load(reloc_load), .lane_now(lane_now), .win_hit(win_hit),
    .mem_fwd(mem_fwd), .lanes(lanes), .acc_write(acc_write),
    .acc_addr(acc_addr), .rdata(rdata)
  );

  assign lane_lo = lanes[0];
  assign lane_hi = lanes[1];

  a_r4_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    sen |-> ($countones({win_hit, mem_fwd}) == 1));
  a_r3_no_reloc_as_master: assert property (@(posedge clk) disable iff (!rst_n)
    bus_master |-> !reloc_load);
endmodule

// File: tb/host_slave_port_test.sv
module host_slave_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_master = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mio = 1'b0, bhe_n = 1'b1;
  logic [21:0] addr = '0;
  logic [15:0] wdata = '0;
  logic sen, win_hit, mem_fwd, lane_lo, lane_hi, acc_write;
  logic [21:0] acc_addr;
  logic [15:0] rdata;

  int checks = 0, fails = 0;

  // reference model state
  int m_reloc = 0;
  bit m_prev = 0;
  bit e_sen, e_hit, e_mem, e_lo, e_hi, e_wr;
  int e_addr = 0, e_rdata = 0;

  always #4 clk = ~clk;

  host_slave_port uut (
    .clk(clk), .rst_n(rst_n), .bus_master(bus_master), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .bhe_n(bhe_n), .addr(addr),
    .wdata(wdata), .sen(sen), .win_hit(win_hit), .mem_fwd(mem_fwd),
    .lane_lo(lane_lo), .lane_hi(lane_hi), .acc_write(acc_write),
    .acc_addr(acc_addr), .rdata(rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reloc = 0; m_prev = 0;
      e_sen = 0; e_hit = 0; e_mem = 0; e_lo = 0; e_hi = 0; e_wr = 0;
      e_addr = 0; e_rdata = 0;
    end else begin
      bit act, inwin, word0;
      int a, lo_b;
      a = int'(addr);
      act = !bus_master && !cs_n && (!rd_n || !wr_n);
      lo_b = (m_reloc / 2) * 128;
      inwin = (a >= lo_b) && (a <= lo_b + 127) && (int'(mio) == m_reloc % 2);
      word0 = ((a - lo_b) < 2);
      if (act && !m_prev) begin
        e_hit = inwin; e_mem = !inwin;
        e_lo = (a % 2) == 0; e_hi = !bhe_n; e_wr = !wr_n; e_addr = a;
        e_rdata = (inwin && wr_n && word0) ? m_reloc : 0;
        if (inwin && !wr_n && word0) begin
          if (e_lo) m_reloc = (m_reloc / 256) * 256 + int'(wdata) % 256;
          if (e_hi) m_reloc = (int'(wdata) / 256) * 256 + m_reloc % 256;
        end
      end else if (!act) begin
        e_hit = 0; e_mem = 0; e_lo = 0; e_hi = 0; e_wr = 0; e_addr = 0; e_rdata = 0;
      end
      e_sen = act;
      m_prev = act;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1/R2 sen", int'(sen), int'(e_sen));
      chk("R4/R5/R11 class", int'({win_hit, mem_fwd}), int'({e_hit, e_mem}));
      chk("R6 lanes", int'({lane_hi, lane_lo}), int'({e_hi, e_lo}));
      chk("R10 dir/addr", int'({acc_write, acc_addr}), int'({e_wr, e_addr[21:0]}));
      chk("R9 rdata", int'(rdata), e_rdata);
    end
  end

  task automatic access(input bit wr, input bit m, input int a, input bit bhe, input int d,
                        input int len);
    @(negedge clk); #1;
    cs_n = 0; rd_n = wr; wr_n = !wr; mio = m; bhe_n = bhe;
    addr = 22'(a); wdata = 16'(d);
    repeat (len) @(negedge clk);
    #1; cs_n = 1; rd_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 sen", int'(sen), 0);
    chk("R8 outs", int'({win_hit, mem_fwd, lane_lo, lane_hi, acc_write}), 0);
    #1 rst_n = 1;
    // I/O read at offset 0: default window at 0, I/O
    access(0, 0, 0, 0, 0, 3);
    // in-range address but memory space: R5
    @(negedge clk); #1; cs_n = 0; rd_n = 0; mio = 1; addr = 22'h10; bhe_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R5 mismatch forwarded", int'({win_hit, mem_fwd}), 1);
    #1; cs_n = 1; rd_n = 1; @(negedge clk);
    // R3: master blocks access and relocation writes
    bus_master = 1;
    access(1, 0, 0, 0, 16'hFFFF, 3);
    chk("R3 sen while master", int'(sen), 0);
    bus_master = 0;
    access(0, 0, 0, 0, 0, 2);
    // R7: program base 0x054A80, memory mapped; write data = (0xA95<<1)|1
    access(1, 0, 0, 0, 16'h152B, 2);
    // R10: same address/space after relocation is now forwarded
    access(0, 0, 0, 0, 0, 2);
    @(negedge clk); #1; cs_n = 0; rd_n = 0; mio = 1; addr = 22'h054A80; bhe_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R9 reloc readback", int'(rdata), 16'h152B);
    chk("R7 new base hit", int'(win_hit), 1);
    #1; cs_n = 1; rd_n = 1; @(negedge clk);
    chk("R2 cleared after end", int'({win_hit, mem_fwd, rdata}), 0);
    // R11 boundaries, R6 byte lanes
    access(0, 1, 22'h054A80 + 127, 0, 0, 2);
    access(0, 1, 22'h054A80 + 128, 1, 0, 2);
    access(0, 1, 22'h054A80 - 1, 0, 0, 2);
    access(0, 0, 22'h054A80, 1, 0, 2);
    access(0, 1, 22'h054A80 + 6, 1, 0, 2);
    // R7: low-byte write switches mapping to I/O only
    access(1, 1, 22'h054A80, 1, 16'hEE2A, 2);
    access(0, 0, 22'h054A80, 0, 0, 2);
    // high-byte write at offset 1 changes upper base bits
    access(1, 0, 22'h054A81, 0, 16'h1100, 2);
    access(0, 0, 22'h088A80, 0, 0, 2);
    // random accesses near the current window
    for (int i = 0; i < 400; i++) begin
      int a;
      a = ((m_reloc / 2) * 128) + $urandom_range(0, 300) - 100;
      if (a < 0) a = 0;
      if ($urandom_range(0, 5) == 0) a = int'($urandom_range(0, 22'h3FFFFF));
      access($urandom_range(0, 3) == 0, 1'($urandom_range(0, 1)), a,
             1'($urandom_range(0, 1)), int'($urandom_range(0, 16'hFFFF)),
             $urandom_range(1, 4));
    end
    repeat (2) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule